// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Readout Controller

This block is the host side of a three-wire serial link to a slow 24-bit sigma-delta converter. The converter has a single output line with two jobs. Between transfers it is a ready flag, and it goes low once a fresh conversion result is waiting. During a transfer it carries the result bits. The controller selects the converter, watches that line and, once it sees the line low, clocks out the 24-bit word. It then turns the offset-binary code into a signed two's-complement value and presents it with a one-cycle strobe.

The serial clock comes from a programmable half-period divider of the system clock. The divider has a floor that keeps each high and low phase at or above the converter's 100 ns minimum. The controller can also send one 8-bit byte on the input line, such as the configuration byte that holds the 3-bit output-rate field. A write request is taken only while the controller is idle. In continuous reading, the controller waits for the ready line to go high and then low again before each new read, so no result is ever fetched twice.

Top module: `sdl_link_ctrl`

## Requirements
- R1: During and right after reset: `adc_cs_n` = 1, `adc_sclk` = 1, `adc_din` = 1, `res_valid` = 0 and `busy` = 0.
- R2: `adc_sclk` is high whenever `adc_cs_n` is high. `adc_cs_n` goes low at least two half-periods before the first falling edge of `adc_sclk`.
- R3: Within a transfer, every low phase and every high phase of `adc_sclk` lasts exactly H system clocks, where H = max(`half_div`, MIN_HALF) and MIN_HALF defaults to 5 (100 ns at 50 MHz).
- R4: A read starts only when `rd_en` = 1, chip select is active and the synchronised `adc_dout_rdy` is low. While the line stays high, no `adc_sclk` edge occurs.
- R5: A read makes exactly 24 rising edges on `adc_sclk`. The converter changes data after each falling edge, and the controller takes one bit per rising edge, MSB first.
- R6: `res_data` is the received 24-bit code with bit 23 inverted. Examples: 0x800000 gives 0x000000, 0xFFFFFF gives 0x7FFFFF, 0x000000 gives 0x800000.
- R7: `res_valid` is high for exactly one cycle per completed read, and `res_data` holds its value until the next read completes.
- R8: After a read, the controller makes no further `adc_sclk` edges until `adc_dout_rdy` has been seen high and then low again, even if the line stays low.
- R9: A write sends `wr_data` MSB first on `adc_din` over 8 rising edges. Any byte is sent unchanged, for example a configuration byte whose bits 2:0 carry the rate field. `adc_din` changes only at falling edges and stays stable through each high phase.
- R10: `busy` is high from the cycle after a request is accepted until chip select is released. A `wr_req` pulse while `busy` = 1 is dropped and causes no write.
- R11: With `rd_en` = 0 and no write, `adc_cs_n` stays high. Clearing `rd_en` while waiting for ready releases chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | Requested serial clock half-period in system clocks |
| rd_en | input | 1 | Enables continuous ready watching and reading |
| wr_req | input | 1 | One-cycle request to send `wr_data` |
| wr_data | input | CMD_W | Byte to send to the converter |
| busy | output | 1 | Controller not idle |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | DATA_W | Signed two's-complement result |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial data to the converter |
| adc_dout_rdy | input | 1 | Converter data line and ready flag |

## Verification
The hardest case to reach from the ports is a ready line that stays low after a read has finished, because a well-behaved converter always raises it. The bench's converter model has a stuck-low switch, so the controller can be left with a low line and no new data. The bench then counts clock edges over a long window and confirms there are none. A second hard case is a write request that arrives while a read is waiting. The bench raises it in that state and checks that the data line never moves.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RWAIT,
    ST_XFER,
    ST_TAIL,
    ST_REARM
  } sdl_state_e;

endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdl_half_timer.sv
module sdl_half_timer #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] last_cnt;
  logic [DIV_W-1:0] cnt;

  always_comb begin
    half_eff = (half_cfg < MIN_V) ? MIN_V : half_cfg;
    last_cnt = half_eff - 1'b1;
  end

  assign tick = run && (cnt >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_NO_BACK_TO_BACK_TICK: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(tick)) |-> !tick); // R3
endmodule

// File: rtl/sdl_rx_shift.sv
module sdl_rx_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)    word_q <= '0;
    else if (shift_en) word_q <= {word_q[W-2:0], bit_in};
  end
endmodule

// File: rtl/sdl_tx_shift.sv
module sdl_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)           sr <= '1;
    else if (load)     sr <= load_val;
    else if (shift_en) sr <= {sr[W-2:0], 1'b1};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/sdl_link_ctrl.sv
module sdl_link_ctrl #(
  parameter int DATA_W      = 24,
  parameter int CMD_W       = 8,
  parameter int DIV_W       = 8,
  parameter int MIN_HALF    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_HALVES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              rd_en,
  input  logic              wr_req,
  input  logic [CMD_W-1:0]  wr_data,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_din,
  input  logic              adc_dout_rdy
);
  import sdl_pkg::*;

  localparam int MAX_BITS = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int BIT_W    = $clog2(MAX_BITS);
  localparam int LEAD_W   = $clog2(LEAD_HALVES + 1);
  localparam logic [BIT_W-1:0]  RD_LAST   = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0]  WR_LAST   = BIT_W'(CMD_W - 1);
  localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_HALVES - 1);
  localparam logic [DIV_W-1:0]  MIN_V     = DIV_W'(MIN_HALF);

  sdl_state_e        state;
  logic              is_rd;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BIT_W-1:0]  last_bit;
  logic [LEAD_W-1:0] lead_cnt;
  logic              rdy_s;
  logic              tick;
  logic              run;
  logic              tx_load, tx_shift, tx_msb;
  logic              rx_clr, rx_shift;
  logic [DATA_W-1:0] rx_word;

  sdl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(adc_dout_rdy), .q(rdy_s)
  );

  sdl_half_timer #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_timer (
    .clk(clk), .rst(rst), .run(run), .half_cfg(half_div), .tick(tick)
  );

  sdl_rx_shift #(.W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .shift_en(rx_shift),
    .bit_in(rdy_s), .word_q(rx_word)
  );

  sdl_tx_shift #(.W(CMD_W)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_val(wr_data),
    .shift_en(tx_shift), .msb(tx_msb)
  );

  always_comb begin
    run      = (state == ST_LEAD) || (state == ST_XFER) || (state == ST_TAIL);
    last_bit = is_rd ? RD_LAST : WR_LAST;
    tx_load  = (state == ST_IDLE) && wr_req;
    tx_shift = (state == ST_XFER) && tick && adc_sclk && !is_rd;
    rx_clr   = (state == ST_RWAIT);
    rx_shift = (state == ST_XFER) && tick && !adc_sclk && is_rd;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      is_rd     <= 1'b0;
      bit_cnt   <= '0;
      lead_cnt  <= '0;
      adc_cs_n  <= 1'b1;
      adc_sclk  <= 1'b1;
      adc_din   <= 1'b1;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          adc_cs_n <= 1'b1;
          adc_sclk <= 1'b1;
          adc_din  <= 1'b1;
          lead_cnt <= '0;
          if (wr_req) begin
            is_rd    <= 1'b0;
            adc_cs_n <= 1'b0;
            state    <= ST_LEAD;
          end else if (rd_en) begin
            is_rd    <= 1'b1;
            adc_cs_n <= 1'b0;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (lead_cnt == LEAD_LAST) begin
              lead_cnt <= '0;
              bit_cnt  <= '0;
              state    <= is_rd ? ST_RWAIT : ST_XFER;
            end else begin
              lead_cnt <= lead_cnt + 1'b1;
            end
          end
        end
        ST_RWAIT: begin
          if (!rd_en) begin
            adc_cs_n <= 1'b1;
            state    <= ST_IDLE;
          end else if (!rdy_s) begin
            bit_cnt <= '0;
            state   <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (adc_sclk) begin
              adc_sclk <= 1'b0;
              if (!is_rd) adc_din <= tx_msb;
            end else begin
              adc_sclk <= 1'b1;
              if (bit_cnt == last_bit) begin
                state <= ST_TAIL;
                if (is_rd) begin
                  res_valid <= 1'b1;
                  res_data  <= {~rx_word[DATA_W-2], rx_word[DATA_W-3:0], rdy_s};
                end
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (is_rd && rd_en) begin
              state <= ST_REARM;
            end else begin
              adc_cs_n <= 1'b1;
              adc_din  <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        ST_REARM: begin
          if (!rd_en) begin
            adc_cs_n <= 1'b1;
            state    <= ST_IDLE;
          end else if (rdy_s) begin
            state <= ST_RWAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Run length of the current serial clock level, kept for the phase check.
  logic             sclk_prev;
  logic [DIV_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b1;
      run_len   <= MIN_V;
    end else begin
      sclk_prev <= adc_sclk;
      if (adc_sclk != sclk_prev) run_len <= DIV_W'(1);
      else if (run_len < MIN_V)  run_len <= run_len + 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk); // R2
  AST_PHASE_MIN: assert property (@(posedge clk) disable iff (rst)
    (adc_sclk != sclk_prev) |-> (run_len >= MIN_V)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R7
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> adc_cs_n); // R10
  AST_DIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adc_cs_n && $past(!adc_cs_n) && adc_sclk && $past(adc_sclk)) |-> $stable(adc_din)); // R9
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER) |-> (bit_cnt <= last_bit)); // R5
endmodule

// File: tb/sdl_link_ctrl_bench.sv
module sdl_link_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  half_div = 8'd2;
  logic        rd_en = 1'b0;
  logic        wr_req = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        busy, res_valid, adc_cs_n, adc_sclk, adc_din;
  logic [23:0] res_data;
  logic        miso_line = 1'b1;

  always #10 clk = ~clk;

  sdl_link_ctrl u_sdl_link_ctrl (
    .clk(clk), .rst(rst), .half_div(half_div), .rd_en(rd_en),
    .wr_req(wr_req), .wr_data(wr_data), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout_rdy(miso_line)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Converter model, evaluated away from the active clock edge.
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [23:0] m_word = '0;
  logic [23:0] go_word = '0;
  bit m_have = 0, m_started = 0, m_cur = 0, stuck = 0;
  int m_idx = 0, go_req = 0, go_seen = 0, clr_req = 0, clr_seen = 0;
  int falls = 0, rd_done = 0, wr_rises = 0, hold_err = 0, idle_err = 0;
  logic [7:0] wr_cap = '0;
  int ph_min = 1000, ph_max = 0, lead_min = 1000;
  bit p_sclk = 1, p_cs = 1, p_din = 1, lead_pend = 0, after_final = 1;
  int t_chg = 0, cs_t = 0;

  task automatic rec(input int len);
    if (len < ph_min) ph_min = len;
    if (len > ph_max) ph_max = len;
  endtask

  always @(negedge clk) begin
    if (clr_req != clr_seen) begin
      clr_seen = clr_req; ph_min = 1000; ph_max = 0; lead_min = 1000;
    end
    if (go_req != go_seen) begin
      go_seen = go_req; m_word = go_word; m_have = 1; m_started = 0; m_idx = 0;
    end
    if (!rst) begin
      if (adc_cs_n && !adc_sclk) idle_err++;
      if (!adc_cs_n && p_cs) begin cs_t = cyc; lead_pend = 1; after_final = 1; end
      if (!adc_cs_n && !p_cs && adc_sclk && p_sclk && (adc_din != p_din)) hold_err++;
      if (p_sclk && !adc_sclk) begin
        falls++;
        if (lead_pend) begin
          if (cyc - cs_t < lead_min) lead_min = cyc - cs_t;
          lead_pend = 0;
        end
        if (!after_final) rec(cyc - t_chg);
        after_final = 0;
        t_chg = cyc;
        if (m_have) begin m_cur = m_word[23 - m_idx]; m_started = 1; end
      end
      if (!p_sclk && adc_sclk) begin
        rec(cyc - t_chg);
        t_chg = cyc;
        if (m_have) begin
          m_idx++;
          if (m_idx == 24) begin m_have = 0; rd_done++; after_final = 1; end
        end else begin
          wr_cap = {wr_cap[6:0], adc_din};
          wr_rises++;
          if (wr_rises % 8 == 0) after_final = 1;
        end
      end
    end
    p_sclk = adc_sclk; p_cs = adc_cs_n; p_din = adc_din;
    miso_line = adc_cs_n ? 1'b1 : (m_have ? (m_started ? m_cur : 1'b0) : !stuck);
  end

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (res_valid) begin got = 1; break; end
    end
  endtask

  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {24'h800000, 24'h000000},
    {24'hFFFFFF, 24'h7FFFFF},
    {24'h000000, 24'h800000},
    {24'h7FFFFF, 24'hFFFFFF},
    {24'hA5C3E1, 24'h25C3E1},
    {24'h123456, 24'h923456}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit got;
    int f0, w0, r0;
    logic [23:0] held;

    repeat (3) @(negedge clk);
    chk(adc_cs_n && adc_sclk && adc_din && !res_valid && !busy, "R1", "outputs in reset",
        {27'd0, adc_cs_n, adc_sclk, adc_din, res_valid, busy}, 32'h1C);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(adc_cs_n && adc_sclk && adc_din && !res_valid && !busy, "R1", "outputs after reset",
        {27'd0, adc_cs_n, adc_sclk, adc_din, res_valid, busy}, 32'h1C);

    repeat (50) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R11", "cs idle with rd_en low", adc_cs_n, 1);

    // Table walk at the divider floor (requested 2, floor 5).
    clr_req++;
    rd_en = 1'b1;
    repeat (60) @(negedge clk);
    chk(falls == 0 && !res_valid, "R4", "no clock while ready high", falls, 0);
    for (int v = 0; v < NV; v++) begin
      r0 = rd_done;
      go_word = VEC[v][47:24];
      go_req++;
      wait_valid(got);
      chk(got, "R7", "valid seen", got, 1);
      chk(res_data == VEC[v][23:0], "R6", "converted result", res_data, VEC[v][23:0]);
      held = res_data;
      @(negedge clk);
      chk(!res_valid && res_data == held, "R7", "pulse one cycle and data held", res_valid, 0);
      chk(rd_done == r0 + 1 && m_idx == 24, "R5", "24 rising edges per read", m_idx, 24);
      repeat (40) @(negedge clk);
    end
    chk(ph_min == 5 && ph_max == 5, "R3", "phase length at floor", ph_max, 5);
    chk(lead_min >= 10, "R2", "select lead before first edge", lead_min, 10);

    // Ready line held low after a read: no second read.
    stuck = 1;
    go_word = 24'h0F0F0F;
    go_req++;
    wait_valid(got);
    chk(res_data == 24'h8F0F0F, "R6", "result before stuck line", res_data, 24'h8F0F0F);
    f0 = falls;
    repeat (400) @(negedge clk);
    chk(falls == f0 && !adc_cs_n, "R8", "no re-read while line stays low", falls - f0, 0);
    stuck = 0;
    repeat (20) @(negedge clk);
    go_word = 24'h00FF00;
    go_req++;
    wait_valid(got);
    chk(got && res_data == 24'h80FF00, "R8", "read after line high then low", res_data, 24'h80FF00);
    repeat (40) @(negedge clk);

    // Write request during a read wait is dropped.
    w0 = wr_rises;
    chk(busy == 1'b1, "R10", "busy while waiting for ready", busy, 1);
    wr_data = 8'h5A;
    wr_req = 1'b1;
    @(negedge clk) wr_req = 1'b0;
    repeat (100) @(negedge clk);
    chk(wr_rises == w0 && adc_din == 1'b1, "R10", "request while busy ignored", wr_rises - w0, 0);
    rd_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(adc_cs_n && !busy, "R11", "rd_en low releases select", adc_cs_n, 1);
    repeat (50) @(negedge clk);
    chk(wr_rises == w0, "R10", "dropped request not replayed", wr_rises - w0, 0);

    // Configuration byte with rate field 3'b011 at a slower divider.
    half_div = 8'd7;
    clr_req++;
    @(negedge clk);
    w0 = wr_rises;
    wr_data = 8'hA3;
    wr_req = 1'b1;
    @(negedge clk) wr_req = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    for (int i = 0; i < 2000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk(wr_cap == 8'hA3, "R9", "byte sent MSB first", wr_cap, 8'hA3);
    chk(wr_rises == w0 + 8, "R9", "8 rising edges", wr_rises - w0, 8);
    chk(hold_err == 0, "R9", "din stable through high phases", hold_err, 0);
    chk(ph_min == 7 && ph_max == 7, "R3", "phase length at divider 7", ph_max, 7);
    chk(lead_min >= 14, "R2", "select lead at divider 7", lead_min, 14);
    chk(idle_err == 0, "R2", "clock high while deselected", idle_err, 0);
    chk(adc_cs_n && adc_din, "R11", "idle after write", {adc_cs_n, adc_din}, 2'b11);

    finish_run();
  end
endmodule